// File: doc/BRIEF.md
# Operand Forwarding and Register-Read Bypass Unit

This block selects source operands in a five-stage in-order integer pipeline. It looks at the two source register numbers of the instruction entering the execute stage. It compares them with the destination register numbers of the older instructions now in the memory stage and the write-back stage. For each operand it then picks one of three values: the value read from the ID/EX operand register, the ALU result held in the EX/MEM pipeline register, or the final value being written back. Both the select code and the chosen operand are outputs. The chosen value enters at the start of execute.

A separate path covers decode-stage reads. A register-file read in decode can target the register that write-back is writing in the same cycle. In that case the read returns the value being written, not the stale stored value. Every value the block forwards comes from a pipeline register. It never takes the memory output or the ALU output of the current cycle. The block is purely combinational, and stall generation is left to other logic.

Top module: `operand_forward_unit`

## Requirements
- R1: When an execute source number equals the memory-stage destination, that stage's write enable is high and the destination is non-zero, the operand select is 2'b10 and the operand equals the EX/MEM ALU result.
- R2: When an execute source number matches the write-back destination (enable high, destination non-zero) and the memory stage does not match, the select is 2'b01 and the operand equals the write-back value.
- R3: When both the memory stage and the write-back stage match the same source, the memory-stage value wins (select 2'b10).
- R4: With no qualifying match, the select is 2'b00 and the operand equals the ID/EX register value for that operand.
- R5: A destination of register 0 never matches, on either stage or on either path, even when the source is 0 and the write enable is high.
- R6: A stage whose write enable is low never produces a match, even when its destination number equals the source.
- R7: Operand 0 and operand 1 are resolved independently, so in the same cycle they may take values from different stages.
- R8: A decode read port whose address equals the non-zero write-back destination while write-back enable is high returns the write-back value. Otherwise it returns the register-file read data.
- R9: The decode read bypass ignores the memory stage: a match only against the memory-stage destination leaves the decode read data unchanged.
- R10: The select code 2'b11 never appears on any operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_addr | input | NUM_SRC x RW | Source register numbers of the instruction entering execute |
| ex_rf_data | input | NUM_SRC x XLEN | Operand values held in the ID/EX register |
| mem_rd_addr | input | RW | Destination register of the memory-stage instruction |
| mem_rd_we | input | 1 | Register write enable of the memory-stage instruction |
| mem_alu_result | input | XLEN | ALU result held in the EX/MEM register |
| wb_rd_addr | input | RW | Destination register of the write-back instruction |
| wb_rd_we | input | 1 | Register write enable of the write-back instruction |
| wb_wdata | input | XLEN | Final write-back value (ALU or load) |
| id_rd_addr | input | NUM_RD x RW | Decode-stage register-file read addresses |
| id_rf_rdata | input | NUM_RD x XLEN | Raw register-file read data |
| ex_fwd_sel | output | NUM_SRC x 2 | Per-operand select: 00 register, 01 write-back, 10 memory |
| ex_opnd | output | NUM_SRC x XLEN | Forwarded operand values at the start of execute |
| id_rdata | output | NUM_RD x XLEN | Decode read data after the write-back bypass |

## Verification
The bench targets the case where both the memory stage and the write-back stage claim the same source. A design with the priority reversed would hand the operand a value that is one instruction too old. It drives register 0 as the destination with the enable high and the source also 0. A design without the zero exclusion would forward a value into a hard-wired zero read. It sets destination matches with the enable low, which a design that skips the enable qualifier would wrongly forward. It also drives a memory-only match at the decode read ports, where a design that compared against the wrong stage would corrupt decode data. A sweep over register numbers with operands pointing at different stages catches any coupling between the two operand paths.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic mem_hit;
        logic wb_hit;
    } hit_pair_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src_addr,
    input  logic [RW-1:0] dst_addr,
    input  logic          dst_we,
    output logic          hit
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = dst_we && (dst_addr != ZERO_REG) && (src_addr == dst_addr);
    end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src_addr,
    input  logic [RW-1:0] mem_rd_addr,
    input  logic          mem_rd_we,
    input  logic [RW-1:0] wb_rd_addr,
    input  logic          wb_rd_we,
    output logic [1:0]    sel
);
    hit_pair_t hits_d;
    fwd_sel_e  sel_d;

    fwd_match #(.RW(RW)) u_mem_cmp (
        .src_addr (src_addr),
        .dst_addr (mem_rd_addr),
        .dst_we   (mem_rd_we),
        .hit      (hits_d.mem_hit)
    );

    fwd_match #(.RW(RW)) u_wb_cmp (
        .src_addr (src_addr),
        .dst_addr (wb_rd_addr),
        .dst_we   (wb_rd_we),
        .hit      (hits_d.wb_hit)
    );

    // Younger producer (memory stage) takes priority over write-back.
    always_comb begin
        if (hits_d.mem_hit) begin
            sel_d = SEL_MEM;
        end else if (hits_d.wb_hit) begin
            sel_d = SEL_WB;
        end else begin
            sel_d = SEL_RF;
        end
        sel = sel_d;
    end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      sel,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] wb_val,
    input  logic [XLEN-1:0] mem_val,
    output logic [XLEN-1:0] out_val
);
    always_comb begin
        case (fwd_sel_e'(sel))
            SEL_MEM: out_val = mem_val;
            SEL_WB:  out_val = wb_val;
            default: out_val = rf_val;
        endcase
    end
endmodule

// File: rtl/operand_forward_unit.sv
module operand_forward_unit #(
    parameter int XLEN    = 32,
    parameter int NREG    = 32,
    parameter int NUM_SRC = 2,
    parameter int NUM_RD  = 2,
    parameter int RW      = $clog2(NREG)
) (
    input  logic [NUM_SRC-1:0][RW-1:0]   ex_src_addr,
    input  logic [NUM_SRC-1:0][XLEN-1:0] ex_rf_data,
    input  logic [RW-1:0]                mem_rd_addr,
    input  logic                         mem_rd_we,
    input  logic [XLEN-1:0]              mem_alu_result,
    input  logic [RW-1:0]                wb_rd_addr,
    input  logic                         wb_rd_we,
    input  logic [XLEN-1:0]              wb_wdata,
    input  logic [NUM_RD-1:0][RW-1:0]    id_rd_addr,
    input  logic [NUM_RD-1:0][XLEN-1:0]  id_rf_rdata,
    output logic [NUM_SRC-1:0][1:0]      ex_fwd_sel,
    output logic [NUM_SRC-1:0][XLEN-1:0] ex_opnd,
    output logic [NUM_RD-1:0][XLEN-1:0]  id_rdata
);
    // Execute-stage operand paths, one per source operand.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ex
        logic [1:0] sel_w;

        fwd_select #(.RW(RW)) u_sel (
            .src_addr    (ex_src_addr[g]),
            .mem_rd_addr (mem_rd_addr),
            .mem_rd_we   (mem_rd_we),
            .wb_rd_addr  (wb_rd_addr),
            .wb_rd_we    (wb_rd_we),
            .sel         (sel_w)
        );

        fwd_mux #(.XLEN(XLEN)) u_mux (
            .sel     (sel_w),
            .rf_val  (ex_rf_data[g]),
            .wb_val  (wb_wdata),
            .mem_val (mem_alu_result),
            .out_val (ex_opnd[g])
        );

        assign ex_fwd_sel[g] = sel_w;
    end

    // Decode-stage read bypass around the register file (write-back only).
    for (genvar r = 0; r < NUM_RD; r++) begin : g_id
        logic byp_hit;

        fwd_match #(.RW(RW)) u_byp_cmp (
            .src_addr (id_rd_addr[r]),
            .dst_addr (wb_rd_addr),
            .dst_we   (wb_rd_we),
            .hit      (byp_hit)
        );

        always_comb begin
            id_rdata[r] = byp_hit ? wb_wdata : id_rf_rdata[r];
        end
    end
endmodule

// File: rtl/operand_forward_unit_chk.sv
module operand_forward_unit_chk #(
    parameter int XLEN    = 32,
    parameter int NUM_SRC = 2,
    parameter int NUM_RD  = 2,
    parameter int RW      = 5
) (
    input logic [NUM_SRC-1:0][RW-1:0]   ex_src_addr,
    input logic [NUM_SRC-1:0][XLEN-1:0] ex_rf_data,
    input logic [XLEN-1:0]              mem_alu_result,
    input logic [XLEN-1:0]              wb_wdata,
    input logic [NUM_RD-1:0][RW-1:0]    id_rd_addr,
    input logic [NUM_RD-1:0][XLEN-1:0]  id_rf_rdata,
    input logic [NUM_SRC-1:0][1:0]      ex_fwd_sel,
    input logic [NUM_SRC-1:0][XLEN-1:0] ex_opnd,
    input logic [NUM_RD-1:0][XLEN-1:0]  id_rdata
);
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!$isunknown({ex_fwd_sel[i], ex_src_addr[i], ex_opnd[i],
                             ex_rf_data[i], mem_alu_result, wb_wdata})) begin
                AST_SEL_LEGAL: assert (ex_fwd_sel[i] != 2'b11); // R10
                if (ex_fwd_sel[i] == 2'b10) begin
                    AST_MEM_OPND: assert (ex_opnd[i] == mem_alu_result); // R1
                end
                if (ex_fwd_sel[i] == 2'b01) begin
                    AST_WB_OPND: assert (ex_opnd[i] == wb_wdata); // R2
                end
                if (ex_fwd_sel[i] == 2'b00) begin
                    AST_RF_OPND: assert (ex_opnd[i] == ex_rf_data[i]); // R4
                end
                if (ex_src_addr[i] == '0) begin
                    AST_ZERO_SRC_NOFWD: assert (ex_fwd_sel[i] == 2'b00); // R5
                end
            end
        end
        for (int j = 0; j < NUM_RD; j++) begin
            if (!$isunknown({id_rd_addr[j], id_rdata[j], id_rf_rdata[j]})) begin
                if (id_rd_addr[j] == '0) begin
                    AST_ZERO_ID_NOBYP: assert (id_rdata[j] == id_rf_rdata[j]); // R5
                end
            end
        end
    end
endmodule

bind operand_forward_unit operand_forward_unit_chk #(
    .XLEN    (XLEN),
    .NUM_SRC (NUM_SRC),
    .NUM_RD  (NUM_RD),
    .RW      (RW)
) u_chk (
    .ex_src_addr    (ex_src_addr),
    .ex_rf_data     (ex_rf_data),
    .mem_alu_result (mem_alu_result),
    .wb_wdata       (wb_wdata),
    .id_rd_addr     (id_rd_addr),
    .id_rf_rdata    (id_rf_rdata),
    .ex_fwd_sel     (ex_fwd_sel),
    .ex_opnd        (ex_opnd),
    .id_rdata       (id_rdata)
);

// File: tb/operand_forward_unit_tb.sv
`timescale 1ns/1ps
module operand_forward_unit_tb;
    localparam int XLEN = 32;
    localparam int RW   = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0][RW-1:0]   ex_src_addr;
    logic [1:0][XLEN-1:0] ex_rf_data;
    logic [RW-1:0]        mem_rd_addr;
    logic                 mem_rd_we;
    logic [XLEN-1:0]      mem_alu_result;
    logic [RW-1:0]        wb_rd_addr;
    logic                 wb_rd_we;
    logic [XLEN-1:0]      wb_wdata;
    logic [1:0][RW-1:0]   id_rd_addr;
    logic [1:0][XLEN-1:0] id_rf_rdata;
    logic [1:0][1:0]      ex_fwd_sel;
    logic [1:0][XLEN-1:0] ex_opnd;
    logic [1:0][XLEN-1:0] id_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    localparam logic [XLEN-1:0] RF0 = 32'h0000_A0A0;
    localparam logic [XLEN-1:0] RF1 = 32'h0000_B1B1;
    localparam logic [XLEN-1:0] MV  = 32'hDEAD_0001;
    localparam logic [XLEN-1:0] WV  = 32'hBEEF_0002;
    localparam logic [XLEN-1:0] ID0 = 32'h1111_0000;
    localparam logic [XLEN-1:0] ID1 = 32'h2222_0000;

    operand_forward_unit u_dut (
        .ex_src_addr    (ex_src_addr),
        .ex_rf_data     (ex_rf_data),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rd_we      (mem_rd_we),
        .mem_alu_result (mem_alu_result),
        .wb_rd_addr     (wb_rd_addr),
        .wb_rd_we       (wb_rd_we),
        .wb_wdata       (wb_wdata),
        .id_rd_addr     (id_rd_addr),
        .id_rf_rdata    (id_rf_rdata),
        .ex_fwd_sel     (ex_fwd_sel),
        .ex_opnd        (ex_opnd),
        .id_rdata       (id_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [RW-1:0] s0, input logic [RW-1:0] s1,
                         input logic [RW-1:0] md, input logic mwe,
                         input logic [RW-1:0] wd, input logic wwe,
                         input logic [RW-1:0] i0, input logic [RW-1:0] i1);
        @(posedge clk);
        ex_src_addr    = {s1, s0};
        ex_rf_data     = {RF1, RF0};
        mem_rd_addr    = md;
        mem_rd_we      = mwe;
        mem_alu_result = MV;
        wb_rd_addr     = wd;
        wb_rd_we       = wwe;
        wb_wdata       = WV;
        id_rd_addr     = {i1, i0};
        id_rf_rdata    = {ID1, ID0};
        @(negedge clk);
    endtask

    task automatic t_idle;
        drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0);
        chk("R4 idle sel0", 64'(ex_fwd_sel[0]), 64'd0);
        chk("R4 idle opnd0", 64'(ex_opnd[0]), 64'(RF0));
        chk("R4 idle opnd1", 64'(ex_opnd[1]), 64'(RF1));
        chk("R8 idle id0", 64'(id_rdata[0]), 64'(ID0));
    endtask

    task automatic t_mem_fwd;
        drive(5'd3, 5'd7, 5'd3, 1'b1, 5'd9, 1'b1, 5'd1, 5'd2);
        chk("R1 mem sel0", 64'(ex_fwd_sel[0]), 64'd2);
        chk("R1 mem opnd0", 64'(ex_opnd[0]), 64'(MV));
        chk("R4 nomatch sel1", 64'(ex_fwd_sel[1]), 64'd0);
    endtask

    task automatic t_wb_fwd;
        drive(5'd4, 5'd12, 5'd8, 1'b1, 5'd12, 1'b1, 5'd1, 5'd2);
        chk("R2 wb sel1", 64'(ex_fwd_sel[1]), 64'd1);
        chk("R2 wb opnd1", 64'(ex_opnd[1]), 64'(WV));
        chk("R4 nomatch opnd0", 64'(ex_opnd[0]), 64'(RF0));
    endtask

    task automatic t_priority;
        drive(5'd6, 5'd6, 5'd6, 1'b1, 5'd6, 1'b1, 5'd1, 5'd2);
        chk("R3 both sel0", 64'(ex_fwd_sel[0]), 64'd2);
        chk("R3 both opnd1", 64'(ex_opnd[1]), 64'(MV));
    endtask

    task automatic t_zero;
        drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 5'd0);
        chk("R5 zero sel0", 64'(ex_fwd_sel[0]), 64'd0);
        chk("R5 zero opnd1", 64'(ex_opnd[1]), 64'(RF1));
        chk("R5 zero id0", 64'(id_rdata[0]), 64'(ID0));
    endtask

    task automatic t_we_low;
        drive(5'd10, 5'd11, 5'd10, 1'b0, 5'd11, 1'b0, 5'd11, 5'd10);
        chk("R6 we low sel0", 64'(ex_fwd_sel[0]), 64'd0);
        chk("R6 we low opnd1", 64'(ex_opnd[1]), 64'(RF1));
        chk("R6 we low id0", 64'(id_rdata[0]), 64'(ID0));
        // memory enabled, write-back disabled: write-back value must not leak
        drive(5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b0, 5'd1, 5'd1);
        chk("R6 wb off sel1", 64'(ex_fwd_sel[1]), 64'd0);
    endtask

    task automatic t_indep;
        drive(5'd14, 5'd15, 5'd14, 1'b1, 5'd15, 1'b1, 5'd1, 5'd2);
        chk("R7 indep sel0", 64'(ex_fwd_sel[0]), 64'd2);
        chk("R7 indep sel1", 64'(ex_fwd_sel[1]), 64'd1);
        chk("R7 indep opnd0", 64'(ex_opnd[0]), 64'(MV));
        chk("R7 indep opnd1", 64'(ex_opnd[1]), 64'(WV));
    endtask

    task automatic t_id_bypass;
        drive(5'd1, 5'd2, 5'd20, 1'b1, 5'd21, 1'b1, 5'd21, 5'd20);
        chk("R8 id hit", 64'(id_rdata[0]), 64'(WV));
        chk("R9 id mem ignored", 64'(id_rdata[1]), 64'(ID1));
    endtask

    task automatic t_sweep;
        for (int r = 0; r < 32; r++) begin
            logic [RW-1:0] a;
            logic [RW-1:0] b;
            logic [1:0] e0;
            logic [1:0] e1;
            a = RW'(r);
            b = RW'(31 - r);
            drive(a, b, a, 1'b1, b, 1'b1, b, a);
            e0 = (r != 0) ? 2'd2 : 2'd0;
            e1 = (b == a) ? e0 : ((b != 0) ? 2'd1 : 2'd0);
            chk("R7 sweep sel0", 64'(ex_fwd_sel[0]), 64'(e0));
            chk("R7 sweep sel1", 64'(ex_fwd_sel[1]), 64'(e1));
            chk("R10 sweep legal", 64'(ex_fwd_sel[0] == 2'b11), 64'd0);
            chk("R8 sweep id0", 64'(id_rdata[0]), 64'((b != 0) ? WV : ID0));
            chk("R9 sweep id1", 64'(id_rdata[1]), 64'((a == b && a != 0) ? WV : ID1));
        end
    endtask

    initial begin
        t_idle();
        t_mem_fwd();
        t_wb_fwd();
        t_priority();
        t_zero();
        t_we_low();
        t_indep();
        t_id_bypass();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule